// File: doc/BRIEF.md
# Symmetric Integer Clock Divider

This block divides a source clock by an integer ratio from 1 to 8. A 3-bit divide code selects the ratio, which is always the code plus one. Code zero sends the source clock straight to the output. Every other code counts source cycles.

If the source clock runs at a 50% duty cycle, the output also runs at 50% for every ratio, odd ratios included. For odd ratios the block forms the output from a rising-edge phase and a copy of that phase taken half a source period later on the falling edge. If the source duty is not 50%, even ratios still give an exact 50% output, because all of their output edges fall on rising source edges.

The divide code is taken into use only at the boundary of an output period, so a code change never produces a cut or stretched high pulse. A run enable comes from the power-down control. While it is low, the counter is parked and the output is held low.

Top module: `symdiv_top`

## Requirements
- R1: While reset is asserted, and while the run enable has not yet been seen high, clk_out stays low whatever the divide code.
- R2: For a divide code c from 1 to 7, the clk_out period is (c+1) source periods.
- R3: With divide code 0, clk_out has the source clock's period and high time, including when the source duty is not 50%.
- R4: For even ratios (odd codes 1, 3, 5, 7), the clk_out high time is exactly half the output period.
- R5: For odd ratios (even codes 2, 4, 6), with a 50% source, the clk_out high time is exactly ratio/2 source periods. Rising output edges follow falling source edges and falling output edges follow rising source edges.
- R6: For even ratios with a non-50% source duty, the clk_out high time is still exactly half the output period.
- R7: A divide code change in the middle of an output period has no effect until the next period boundary. Each high pulse has the full high time of either the old or the new ratio.
- R8: When the run enable is low, clk_out is held low.
- R9: After the run enable goes high, the first clk_out rising edge for an even ratio falls on the second rising source edge after the enable changes. That first pulse has the full high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| arst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | CODE_W (3) | Divide code; ratio is code plus one, 0 means bypass |
| run_en | input | 1 | Run enable from power-down control; low parks the divider |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume three things about the inputs. The divide code and the run enable change only while the source clock is high, away from its rising edge. Reset is released while the source clock is low. The source clock never pauses.

The stimulus meets these assumptions. Every code and enable change is driven a short delay after a rising source edge, shorter than the shortest high phase used. Reset is released in the middle of a low phase. Under these conditions the assertions can rely on three relations. The parked counter always sits at the last count of the loaded code. The loaded code changes only when the count returns to zero. The rising-edge phase stays idle during bypass.

// File: rtl/symdiv_pkg.sv
package symdiv_pkg;

   // Output ratio for a divide code: the code plus one.
   function automatic int ratio_of(input int code);
      return code + 1;
   endfunction

   // Number of source cycles the rising-edge phase stays high in one
   // output period. For even ratios this is exactly half. For odd ratios
   // it is half rounded up; the falling-edge copy trims the extra half cycle.
   function automatic int phase_len(input int code);
      return (code + 2) / 2;
   endfunction

   // An even code gives an odd ratio.
   function automatic logic is_odd_ratio(input int code);
      return (code % 2) == 0;
   endfunction

endpackage

// File: rtl/symdiv_phase_gen.sv
module symdiv_phase_gen
   import symdiv_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              en,
   input  logic [CODE_W-1:0] code_in,
   output logic              en_q,
   output logic [CODE_W-1:0] active_code,
   output logic              phase_a
);

   logic [CODE_W-1:0] count_q;
   logic              wrap;

   assign wrap = (count_q == active_code);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         en_q        <= 1'b0;
         count_q     <= '0;
         active_code <= '0;
         phase_a     <= 1'b0;
      end else begin
         en_q <= en;
         if (!en_q) begin
            // Park at the last count so that the first enabled edge starts a period.
            active_code <= code_in;
            count_q     <= code_in;
            phase_a     <= 1'b0;
         end else if (wrap) begin
            active_code <= code_in;
            count_q     <= '0;
            phase_a     <= (code_in != '0);
         end else begin
            count_q <= count_q + 1'b1;
            phase_a <= ((int'(count_q) + 1) < phase_len(int'(active_code)));
         end
      end
   end

   a_r2_count_in_range: assert property (@(posedge clk) disable iff (!arst_n)
      count_q <= active_code);

   a_r7_code_only_at_boundary: assert property (@(posedge clk) disable iff (!arst_n)
      (en_q && $past(en_q) && !$stable(active_code)) |-> (count_q == '0));

   a_r8_parked_low: assert property (@(posedge clk) disable iff (!arst_n)
      !en_q |=> (!phase_a && count_q == active_code));

endmodule

// File: rtl/symdiv_half_shift.sv
module symdiv_half_shift (
   input  logic clk,
   input  logic arst_n,
   input  logic phase_a,
   input  logic en_q,
   output logic phase_b,
   output logic en_low
);

   // Falling-edge copies: the phase delayed by half a source period, and
   // the enable realigned to gate the bypass path while the clock is low.
   always_ff @(negedge clk or negedge arst_n) begin
      if (!arst_n) begin
         phase_b <= 1'b0;
         en_low  <= 1'b0;
      end else begin
         phase_b <= phase_a;
         en_low  <= en_q;
      end
   end

endmodule

// File: rtl/symdiv_out_sel.sv
module symdiv_out_sel
   import symdiv_pkg::*;
#(
   parameter int CODE_W        = 3,
   parameter bit SYMMETRIC_ODD = 1'b1
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic [CODE_W-1:0] active_code,
   input  logic              phase_a,
   input  logic              phase_b,
   input  logic              en_low,
   output logic              clk_out
);

   logic bypass;
   logic divided;

   assign bypass = (active_code == '0);

   generate
      if (SYMMETRIC_ODD) begin : g_sym
         logic odd_sel;
         assign odd_sel = is_odd_ratio(int'(active_code));
         assign divided = odd_sel ? (phase_a & phase_b) : phase_a;
      end else begin : g_plain
         assign divided = phase_a;
      end
   endgenerate

   assign clk_out = bypass ? (clk & en_low) : divided;

   a_r3_bypass_phase_idle: assert property (@(posedge clk) disable iff (!arst_n)
      bypass |-> !phase_a);

endmodule

// File: rtl/symdiv_top.sv
module symdiv_top #(
   parameter int CODE_W        = 3,
   parameter bit SYMMETRIC_ODD = 1'b1
) (
   input  logic              clk_src,
   input  logic              arst_n,
   input  logic [CODE_W-1:0] div_code,
   input  logic              run_en,
   output logic              clk_out
);

   localparam int MAX_RATIO = 1 << CODE_W;

   generate
      if (CODE_W < 1 || CODE_W > 6) begin : g_bad_width
         $error("symdiv_top: CODE_W must be 1..6, max ratio %0d", MAX_RATIO);
      end
   endgenerate

   logic              en_q;
   logic              en_low;
   logic [CODE_W-1:0] active_code;
   logic              phase_a;
   logic              phase_b;

   symdiv_phase_gen #(.CODE_W(CODE_W)) u_phase (
      .clk         (clk_src),
      .arst_n      (arst_n),
      .en          (run_en),
      .code_in     (div_code),
      .en_q        (en_q),
      .active_code (active_code),
      .phase_a     (phase_a)
   );

   symdiv_half_shift u_shift (
      .clk     (clk_src),
      .arst_n  (arst_n),
      .phase_a (phase_a),
      .en_q    (en_q),
      .phase_b (phase_b),
      .en_low  (en_low)
   );

   symdiv_out_sel #(.CODE_W(CODE_W), .SYMMETRIC_ODD(SYMMETRIC_ODD)) u_out (
      .clk         (clk_src),
      .arst_n      (arst_n),
      .active_code (active_code),
      .phase_a     (phase_a),
      .phase_b     (phase_b),
      .en_low      (en_low),
      .clk_out     (clk_out)
   );

   a_r1_low_until_enabled: assert property (@(posedge clk_src) disable iff (!arst_n)
      (!en_q && !en_low) |-> !clk_out);

endmodule

// File: tb/symdiv_top_test.sv
`timescale 1ns/1ps
module symdiv_top_test;

   logic       clk_src = 1'b0;
   logic       arst_n  = 1'b0;
   logic [2:0] div_code = 3'd0;
   logic       run_en  = 1'b0;
   logic       clk_out;

   real t_hi = 4.0;
   real t_lo = 4.0;
   int  checks = 0;
   int  errors = 0;

   symdiv_top uut (
      .clk_src  (clk_src),
      .arst_n   (arst_n),
      .div_code (div_code),
      .run_en   (run_en),
      .clk_out  (clk_out)
   );

   // 125 MHz source by default; the high/low split can be changed.
   initial begin
      forever begin
         clk_src = 1'b1;
         #(t_hi);
         clk_src = 1'b0;
         #(t_lo);
      end
   end

   initial begin
      #(8.0 * 150000);
      errors = errors + 1;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic bit near(real a, real b);
      return (a - b < 0.01) && (b - a < 0.01);
   endfunction

   task automatic check_real(string req, real act, real exp);
      checks = checks + 1;
      if (!near(act, exp)) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
      end
   endtask

   // Change inputs a little after a rising source edge.
   task automatic step_after_rise(int n);
      for (int i = 0; i < n; i++) @(posedge clk_src);
      #1;
   endtask

   // R1: reset and pre-enable state
   task automatic test_reset();
      int bad = 0;
      for (int i = 0; i < 12; i++) begin
         #1.5;
         if (clk_out !== 1'b0) bad++;
      end
      @(negedge clk_src); #2;
      arst_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         #1.5;
         if (clk_out !== 1'b0) bad++;
      end
      checks = checks + 1;
      if (bad != 0) begin
         errors = errors + 1;
         $display("FAIL R1: actual %0d high samples expected 0", bad);
      end
   endtask

   // Measure one full output period and high time for a code (R2 R3 R4 R5 R6).
   task automatic measure_code(int code, string req);
      real t1, t2, t3, src_p, n;
      step_after_rise(1);
      div_code = code[2:0];
      step_after_rise(20);
      src_p = t_hi + t_lo;
      n = code + 1;
      @(posedge clk_out); t1 = $realtime;
      @(negedge clk_out); t2 = $realtime;
      @(posedge clk_out); t3 = $realtime;
      check_real({req, " period"}, t3 - t1, n * src_p);
      if (code == 0)
         check_real({req, " high"}, t2 - t1, t_hi);
      else
         check_real({req, " high"}, t2 - t1, n * src_p / 2.0);
   endtask

   // R7: code change inside a pulse waits for the boundary
   task automatic test_code_change();
      real tr, w;
      int bad = 0;
      step_after_rise(1);
      div_code = 3'd3;
      step_after_rise(20);
      for (int i = 0; i < 6; i++) begin
         @(posedge clk_out); tr = $realtime;
         if (i == 2) begin #3; div_code = 3'd5; end
         @(negedge clk_out); w = $realtime - tr;
         if (i <= 2) check_real("R7 old pulse kept", w, 16.0);
         else if (!near(w, 16.0) && !near(w, 24.0)) bad++;
      end
      checks = checks + 1;
      if (bad != 0) begin
         errors = errors + 1;
         $display("FAIL R7: actual %0d short pulses expected 0", bad);
      end
      @(posedge clk_out); tr = $realtime;
      @(negedge clk_out);
      check_real("R7 new ratio high", $realtime - tr, 24.0);
   endtask

   // R8 and R9: disable holds low, re-enable restarts cleanly
   task automatic test_enable();
      int  bad = 0;
      real ten, tr;
      step_after_rise(1);
      run_en = 1'b0;
      div_code = 3'd3;
      step_after_rise(4);
      for (int i = 0; i < 40; i++) begin
         #1.5;
         if (clk_out !== 1'b0) bad++;
      end
      checks = checks + 1;
      if (bad != 0) begin
         errors = errors + 1;
         $display("FAIL R8: actual %0d high samples expected 0", bad);
      end
      step_after_rise(1);
      #1;
      ten = $realtime;
      run_en = 1'b1;
      @(posedge clk_out); tr = $realtime;
      check_real("R9 first rise delay", tr - ten, 14.0);
      @(negedge clk_out);
      check_real("R9 first pulse high", $realtime - tr, 16.0);
   endtask

   initial begin
      test_reset();
      step_after_rise(1);
      run_en = 1'b1;
      measure_code(0, "R3 bypass");
      measure_code(1, "R2 R4 ratio2");
      measure_code(2, "R2 R5 ratio3");
      measure_code(3, "R2 R4 ratio4");
      measure_code(4, "R2 R5 ratio5");
      measure_code(5, "R2 R4 ratio6");
      measure_code(6, "R2 R5 ratio7");
      measure_code(7, "R2 R4 ratio8");
      test_code_change();
      test_enable();
      // Non-50% source: 3 ns high, 5 ns low.
      step_after_rise(1);
      t_hi = 3.0;
      t_lo = 5.0;
      measure_code(0, "R3 bypass skewed");
      measure_code(1, "R6 ratio2 skewed");
      measure_code(3, "R6 ratio4 skewed");
      measure_code(7, "R6 ratio8 skewed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule